// File: doc/BRIEF.md
# Serial Input Interrupt Detector

This block turns the input values captured by a serial GPIO shifter into interrupts. At the end of every shift burst the shifter delivers one wide sample vector together with a one-cycle valid pulse. Every (port, bit index) pair in that vector is an interrupt source. Each source can fire on a level, on either edge, on a falling edge or on a rising edge, and it latches a pending flag that software clears by writing a one to it.

State is organised by bit index. For each bit index there is one word per register kind, and port p occupies bit p of that word. The trigger type of a source is two bits wide and is split over two trigger words: a low-bit word and a high-bit word. A per-bit-index identity word shows the sources that are both pending and enabled. A single master enable gates the OR of all identity bits onto one interrupt output.

Software reaches the block through a flat word-wide register port with a single write strobe and a combinational read. The serial shifting itself is outside the block.

Top module: `serin_irq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears every stored word, the master enable, the sample history and all pending flags. After reset `irq` is low and every readable register reads zero.
- R2: A register address is `region*8 + index` with the default of 4 bit indices. The regions are: 0 configuration, where index 0 bit 0 is the master enable; 1 trigger, where index b holds the low type bits of bit index b and index 4+b holds the high type bits; 2 level polarity; 3 enable; 4 acknowledge, which is write-only and reads zero; 5 identity, which is read-only. Bit p of each word belongs to port p. Writes take effect at the clock edge where `reg_wr` is high. `reg_rdata` shows the addressed word combinationally.
- R3: Trigger codes are {high bit, low bit}: 0 level, 1 either edge, 2 falling edge, 3 rising edge. An edge is judged against the previously accepted sample. The pending flag sets at the clock edge that accepts the sample.
- R4: The first sample accepted after reset only establishes the history. It creates no edge event. Level sources may still fire on it.
- R5: A level source with polarity 0 is active while its input is 1, and with polarity 1 while its input is 0. It sets pending on every accepted sample in which it is active, so it re-arms on the next sample after an acknowledge.
- R6: A pending flag holds until acknowledged. Writing 1 to bit p of acknowledge word b clears that flag. Writing 0 has no effect. If a new event and an acknowledge of the same source occur in the same cycle, the flag stays set.
- R7: Identity word b equals pending AND enable for bit index b. Pending flags are recorded whether or not the source is enabled.
- R8: `irq` is the OR of all identity bits, gated by the master enable. It follows register state without further delay.
- R9: Writing trigger or polarity words never sets a pending flag by itself. Only an accepted sample does.
- R10: Sample bit `sample_bits[b*NPORTS + p]` is the input of port p at bit index b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | One-cycle pulse: a new burst sample is present |
| sample_bits | input | NBITS*NPORTS | Captured inputs, bit index major |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (region, index) |
| reg_wdata | input | NPORTS | Register write data |
| reg_rdata | output | NPORTS | Register read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench walks one source through every trigger code. A design that compares against the wrong history, or that mixes up rising and falling, sets pending on the wrong sample. It then hits the first sample after reset with a half-set vector under rising-edge triggers: a design without priming would report sixteen spurious sources. Further directed tests cover these points: an acknowledge that coincides with a new event (a wrong priority loses the event); level re-arming after an acknowledge; pending recorded while disabled; master gating; and rewriting the trigger type with no sample (an intermediate code that sets pending would show in the identity word).

// File: rtl/serin_irq_pkg.sv
// Shared types for the serial input interrupt detector.
package serin_irq_pkg;

    // Trigger type of one source, {high bit, low bit}
    typedef enum logic [1:0] {
        TRIG_LEVEL    = 2'd0,
        TRIG_ANY_EDGE = 2'd1,
        TRIG_FALL     = 2'd2,
        TRIG_RISE     = 2'd3
    } trig_e;

    // Address regions of the register port
    typedef enum logic [2:0] {
        RG_CFG   = 3'd0,
        RG_TRIG  = 3'd1,
        RG_POL   = 3'd2,
        RG_ENA   = 3'd3,
        RG_ACK   = 3'd4,
        RG_IDENT = 3'd5
    } region_e;

    // Event decision for one source on an accepted sample
    function automatic logic src_hit(input logic [1:0] ttype, input logic pol,
                                     input logic cur, input logic prv,
                                     input logic armed);
        logic hit;
        case (trig_e'(ttype))
            TRIG_LEVEL:    hit = cur ^ pol;
            TRIG_ANY_EDGE: hit = armed & (cur ^ prv);
            TRIG_FALL:     hit = armed & prv & ~cur;
            default:       hit = armed & cur & ~prv;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/serin_irq_regs.sv
// Register file: configuration, trigger, polarity and enable words, an
// acknowledge pulse decoder and the read multiplexer.
// Assumes one access per cycle; the read is combinational on reg_addr.
module serin_irq_regs
    import serin_irq_pkg::*;
#(
    parameter int NPORTS = 32,
    parameter int NBITS  = 4,
    localparam int IDX_W  = $clog2(2 * NBITS),
    localparam int ADDR_W = IDX_W + 3,
    localparam int FLAT_W = NBITS * NPORTS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NPORTS-1:0]     wdata,
    output logic [NPORTS-1:0]     rdata,
    input  logic [FLAT_W-1:0]     ident_flat,
    output logic                  master_en,
    output logic [FLAT_W-1:0]     trig_lo_flat,
    output logic [FLAT_W-1:0]     trig_hi_flat,
    output logic [FLAT_W-1:0]     pol_flat,
    output logic [FLAT_W-1:0]     ena_flat,
    output logic [FLAT_W-1:0]     ack_flat
);

    logic [2:0]        region;
    logic [IDX_W-1:0]  idx;
    logic [NPORTS-1:0] trig_q [2*NBITS];
    logic [NPORTS-1:0] pol_q  [NBITS];
    logic [NPORTS-1:0] ena_q  [NBITS];

    assign region = addr[ADDR_W-1:IDX_W];
    assign idx    = addr[IDX_W-1:0];

    // Master enable in configuration word 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_en <= 1'b0;
        end else if (wr_en && region == RG_CFG && idx == '0) begin
            master_en <= wdata[0];
        end
    end

    // Trigger low/high words
    always_ff @(posedge clk) begin
        for (int k = 0; k < 2 * NBITS; k++) begin
            if (!rst_n) begin
                trig_q[k] <= '0;
            end else if (wr_en && region == RG_TRIG && int'(idx) == k) begin
                trig_q[k] <= wdata;
            end
        end
    end

    // Polarity and enable words
    always_ff @(posedge clk) begin
        for (int k = 0; k < NBITS; k++) begin
            if (!rst_n) begin
                pol_q[k] <= '0;
                ena_q[k] <= '0;
            end else if (wr_en && int'(idx) == k) begin
                if (region == RG_POL) pol_q[k] <= wdata;
                if (region == RG_ENA) ena_q[k] <= wdata;
            end
        end
    end

    // Flatten words and decode acknowledge pulses per bit index
    for (genvar b = 0; b < NBITS; b++) begin : g_word
        assign trig_lo_flat[b*NPORTS +: NPORTS] = trig_q[b];
        assign trig_hi_flat[b*NPORTS +: NPORTS] = trig_q[NBITS + b];
        assign pol_flat[b*NPORTS +: NPORTS]     = pol_q[b];
        assign ena_flat[b*NPORTS +: NPORTS]     = ena_q[b];
        assign ack_flat[b*NPORTS +: NPORTS]     =
            (wr_en && region == RG_ACK && int'(idx) == b) ? wdata : '0;
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (region)
            RG_CFG:   if (idx == '0) rdata[0] = master_en;
            RG_TRIG:  for (int k = 0; k < 2 * NBITS; k++)
                          if (int'(idx) == k) rdata = trig_q[k];
            RG_POL:   for (int k = 0; k < NBITS; k++)
                          if (int'(idx) == k) rdata = pol_q[k];
            RG_ENA:   for (int k = 0; k < NBITS; k++)
                          if (int'(idx) == k) rdata = ena_q[k];
            RG_IDENT: for (int k = 0; k < NBITS; k++)
                          if (int'(idx) == k) rdata = ident_flat[k*NPORTS +: NPORTS];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/serin_irq_lane.sv
// One bit index: sample history and pending flags for all ports.
// Assumes smp_valid is a single-cycle pulse; an event beats an acknowledge.
module serin_irq_lane
    import serin_irq_pkg::*;
#(
    parameter int NPORTS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              armed,
    input  logic [NPORTS-1:0] smp_word,
    input  logic [NPORTS-1:0] trig_lo,
    input  logic [NPORTS-1:0] trig_hi,
    input  logic [NPORTS-1:0] pol,
    input  logic [NPORTS-1:0] ack_word,
    output logic [NPORTS-1:0] pend_word
);

    logic [NPORTS-1:0] prev_q;
    logic [NPORTS-1:0] hit;

    // Per-port event decision
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign hit[p] = smp_valid &
            src_hit({trig_hi[p], trig_lo[p]}, pol[p], smp_word[p], prev_q[p], armed);
    end

    // History of the last accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_q <= '0;
        else if (smp_valid) prev_q <= smp_word;
    end

    // Pending flags: set by events, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) pend_word <= '0;
        else        pend_word <= (pend_word & ~ack_word) | hit;
    end

endmodule

// File: rtl/serin_irq_combine.sv
// Identity words (pending AND enable) and the gated interrupt output.
// Purely combinational; assumes all inputs are registered upstream.
module serin_irq_combine #(
    parameter int NPORTS = 32,
    parameter int NBITS  = 4,
    localparam int FLAT_W = NBITS * NPORTS
) (
    input  logic [FLAT_W-1:0] pend_flat,
    input  logic [FLAT_W-1:0] ena_flat,
    input  logic              master_en,
    output logic [FLAT_W-1:0] ident_flat,
    output logic              irq
);

    logic [NBITS-1:0] word_any;

    // Per-bit-index identity and its OR
    for (genvar b = 0; b < NBITS; b++) begin : g_id
        assign ident_flat[b*NPORTS +: NPORTS] =
            pend_flat[b*NPORTS +: NPORTS] & ena_flat[b*NPORTS +: NPORTS];
        assign word_any[b] = |ident_flat[b*NPORTS +: NPORTS];
    end

    // Master gate
    assign irq = master_en & (|word_any);

endmodule

// File: rtl/serin_irq.sv
// Top of the serial input interrupt detector: register file, one lane per
// bit index and the identity/interrupt combiner.
// Assumes sample_valid pulses once per completed burst.
module serin_irq #(
    parameter int NPORTS = 32,
    parameter int NBITS  = 4,
    localparam int IDX_W  = $clog2(2 * NBITS),
    localparam int ADDR_W = IDX_W + 3,
    localparam int FLAT_W = NBITS * NPORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [FLAT_W-1:0] sample_bits,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPORTS-1:0] reg_wdata,
    output logic [NPORTS-1:0] reg_rdata,
    output logic              irq
);

    logic              master_en;
    logic              primed_q;
    logic [FLAT_W-1:0] trig_lo_flat, trig_hi_flat, pol_flat, ena_flat;
    logic [FLAT_W-1:0] ack_flat, pend_flat, ident_flat;

    // Marks that a history sample exists
    always_ff @(posedge clk) begin
        if (!rst_n)            primed_q <= 1'b0;
        else if (sample_valid) primed_q <= 1'b1;
    end

    serin_irq_regs #(.NPORTS(NPORTS), .NBITS(NBITS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .ident_flat   (ident_flat),
        .master_en    (master_en),
        .trig_lo_flat (trig_lo_flat),
        .trig_hi_flat (trig_hi_flat),
        .pol_flat     (pol_flat),
        .ena_flat     (ena_flat),
        .ack_flat     (ack_flat)
    );

    for (genvar b = 0; b < NBITS; b++) begin : g_lane
        serin_irq_lane #(.NPORTS(NPORTS)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (sample_valid),
            .armed     (primed_q),
            .smp_word  (sample_bits[b*NPORTS +: NPORTS]),
            .trig_lo   (trig_lo_flat[b*NPORTS +: NPORTS]),
            .trig_hi   (trig_hi_flat[b*NPORTS +: NPORTS]),
            .pol       (pol_flat[b*NPORTS +: NPORTS]),
            .ack_word  (ack_flat[b*NPORTS +: NPORTS]),
            .pend_word (pend_flat[b*NPORTS +: NPORTS])
        );
    end

    serin_irq_combine #(.NPORTS(NPORTS), .NBITS(NBITS)) u_combine (
        .pend_flat  (pend_flat),
        .ena_flat   (ena_flat),
        .master_en  (master_en),
        .ident_flat (ident_flat),
        .irq        (irq)
    );

endmodule

// File: rtl/serin_irq_checker.sv
// Temporal properties of the interrupt detector, bound to its top.
module serin_irq_checker #(
    parameter int NPORTS = 32,
    parameter int NBITS  = 4,
    localparam int FLAT_W = NBITS * NPORTS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_valid,
    input logic              irq,
    input logic              master,
    input logic [FLAT_W-1:0] pend_flat,
    input logic [FLAT_W-1:0] ack_flat
);

    assert_irq_needs_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> master);

    assert_irq_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_flat != '0));

    assert_no_set_without_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ((pend_flat & ~$past(pend_flat)) == '0));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && ack_flat != '0) |=> ((pend_flat & $past(ack_flat)) == '0));

endmodule

bind serin_irq serin_irq_checker #(.NPORTS(NPORTS), .NBITS(NBITS)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .irq          (irq),
    .master       (master_en),
    .pend_flat    (pend_flat),
    .ack_flat     (ack_flat)
);

// File: tb/serin_irq_test.sv
module serin_irq_test;

    localparam int NP = 32;
    localparam int NB = 4;
    localparam int SP = 5;   // port of the table source
    localparam int SB = 2;   // bit index of the table source

    // Table step: {op[1:0], arg[1:0], expected identity bit, pad[2:0]}
    // op 0 sample value arg[0]; 1 set trigger type arg; 2 acknowledge; 3 set polarity arg[0]
    localparam logic [7:0] STEPS [23] = '{
        8'b01_11_0_000, 8'b00_01_1_000, 8'b00_01_1_000, 8'b10_00_0_000,
        8'b00_00_0_000, 8'b01_10_0_000, 8'b00_01_0_000, 8'b00_00_1_000,
        8'b10_00_0_000, 8'b01_01_0_000, 8'b00_01_1_000, 8'b10_00_0_000,
        8'b00_00_1_000, 8'b10_00_0_000, 8'b01_00_0_000, 8'b00_00_0_000,
        8'b00_01_1_000, 8'b10_00_0_000, 8'b00_01_1_000, 8'b11_01_1_000,
        8'b10_00_0_000, 8'b00_01_0_000, 8'b00_00_1_000
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sample_valid = 1'b0;
    logic [NB*NP-1:0] sample_bits = '0;
    logic             reg_wr = 1'b0;
    logic [5:0]       reg_addr = '0;
    logic [NP-1:0]    reg_wdata = '0;
    logic [NP-1:0]    reg_rdata;
    logic             irq;

    int checks = 0;
    int errors = 0;
    logic [NP-1:0] trig_sh [2*NB];
    logic [NP-1:0] rv;

    always #2 clk = ~clk;

    serin_irq uut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_bits(sample_bits),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [5:0] ad(input int region, input int index);
        return 6'(region * 8 + index);
    endfunction

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; sample_valid = 1'b0; reg_wr = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
        for (int k = 0; k < 2 * NB; k++) trig_sh[k] = '0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [NP-1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [NP-1:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic smp(input logic [NB*NP-1:0] v);
        @(negedge clk); sample_bits = v; sample_valid = 1'b1;
        @(posedge clk); #1; sample_valid = 1'b0;
    endtask

    task automatic set_type(input int b, input int p, input logic [1:0] t);
        trig_sh[b][p] = t[0];
        trig_sh[NB + b][p] = t[1];
        wr(ad(1, b), trig_sh[b]);
        wr(ad(1, NB + b), trig_sh[NB + b]);
    endtask

    task automatic src_sample(input logic v);
        logic [NB*NP-1:0] s;
        s = '0;
        s[SB*NP + SP] = v;
        smp(s);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [NB*NP-1:0] v;
        do_reset();

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(ad(0, 0), rv); chk("R1 config", rv, 32'h0);
        rd(ad(1, NB + 1), rv); chk("R1 trigger high", rv, 32'h0);
        rd(ad(5, 0), rv); chk("R1 identity", rv, 32'h0);

        // R4, R10: first sample only primes history for rising triggers
        wr(ad(0, 0), 32'h1);
        wr(ad(3, 0), 32'hFFFF_FFFF);
        wr(ad(1, 0), 32'hFFFF_FFFF);
        wr(ad(1, NB), 32'hFFFF_FFFF);
        v = '0; v[31:0] = 32'hFFFF_0000;
        smp(v);
        rd(ad(5, 0), rv); chk("R4 first sample no edge", rv, 32'h0);
        chk("R4 irq", {31'b0, irq}, 32'h0);
        v[31:0] = 32'hFFFF_FFFF;
        smp(v);
        rd(ad(5, 0), rv); chk("R10 rising on low ports", rv, 32'h0000_FFFF);
        chk("R8 irq on", {31'b0, irq}, 32'h1);

        // Table walk on one source (R3, R5, R6, R9)
        do_reset();
        wr(ad(0, 0), 32'h1);
        wr(ad(3, SB), 32'h1 << SP);
        src_sample(1'b0);
        for (int i = 0; i < 23; i++) begin
            logic [1:0] op, arg;
            logic       ex;
            {op, arg, ex} = STEPS[i][7:3];
            case (op)
                2'd0: src_sample(arg[0]);
                2'd1: set_type(SB, SP, arg);
                2'd2: wr(ad(4, SB), 32'h1 << SP);
                default: wr(ad(2, SB), {31'b0, arg[0]} << SP);
            endcase
            rd(ad(5, SB), rv);
            chk($sformatf("R3 R5 R6 R9 step %0d identity", i), rv, {31'b0, ex} << SP);
            chk($sformatf("R8 step %0d irq", i), {31'b0, irq}, {31'b0, ex});
        end

        // R8: master gate (source pending, level active low, input 0)
        wr(ad(0, 0), 32'h0);
        chk("R8 master off irq", {31'b0, irq}, 32'h0);
        rd(ad(5, SB), rv); chk("R8 identity kept", rv, 32'h1 << SP);
        wr(ad(0, 0), 32'h1);
        chk("R8 master on irq", {31'b0, irq}, 32'h1);

        // R7: pending recorded while disabled
        wr(ad(3, SB), 32'h0);
        wr(ad(4, SB), 32'h1 << SP);
        src_sample(1'b0);
        rd(ad(5, SB), rv); chk("R7 disabled identity", rv, 32'h0);
        chk("R7 disabled irq", {31'b0, irq}, 32'h0);
        wr(ad(3, SB), 32'h1 << SP);
        rd(ad(5, SB), rv); chk("R7 re-enabled identity", rv, 32'h1 << SP);

        // R6: zero and foreign acknowledge bits have no effect
        wr(ad(4, SB), 32'h0);
        rd(ad(5, SB), rv); chk("R6 ack zero", rv, 32'h1 << SP);
        wr(ad(4, SB), 32'h1 << (SP + 1));
        rd(ad(5, SB), rv); chk("R6 ack other port", rv, 32'h1 << SP);
        rd(ad(4, SB), rv); chk("R2 ack reads zero", rv, 32'h0);

        // R6: event and acknowledge in the same cycle -> stays set
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ad(4, SB); reg_wdata = 32'h1 << SP;
        sample_bits = '0; sample_valid = 1'b1;
        @(posedge clk); #1; reg_wr = 1'b0; sample_valid = 1'b0;
        rd(ad(5, SB), rv); chk("R6 event beats ack", rv, 32'h1 << SP);

        // R9: cycling all trigger codes with no sample sets nothing
        wr(ad(4, SB), 32'h1 << SP);
        set_type(SB, SP, 2'd3);
        set_type(SB, SP, 2'd1);
        set_type(SB, SP, 2'd2);
        set_type(SB, SP, 2'd0);
        rd(ad(5, SB), rv); chk("R9 type change no pending", rv, 32'h0);
        rd(ad(1, NB + SB), rv); chk("R2 trigger high word", rv, 32'h0);
        // R5: active-low level still present re-arms on next sample
        src_sample(1'b0);
        rd(ad(5, SB), rv); chk("R5 re-arm", rv, 32'h1 << SP);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule